// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects a set of interrupt inputs on behalf of a processor core. Each input is watched for a rising edge, and the edge is held in a sticky pending bit, so a device may pulse its line and drop it before the core responds. Sources are grouped into levels. Source `s` belongs to level `s / (N_SRC / N_LVL)`, so with the defaults sources 0–1 form level 0, 2–3 level 1, 4–5 level 2 and 6–7 level 3. A pending source is eligible only when three enables are on: its own enable bit, the mask bit of its level, and the global interrupt enable kept inside the block.

Among eligible sources, the winner is chosen in two tiers. First comes a programmable ranking of the levels. Then, inside the winning level, the lowest source index wins. The block raises a registered request towards the core and presents the winner's vector address. When the core acknowledges, the block turns off the global enable, so the handler cannot be preempted, and it clears the winner's pending bit. A return strobe from the core turns the global enable back on.

Top module: `lpic_top`

## Requirements
- R1: After synchronous reset, `irq_o`, `ie_o`, `pend_o` and `vec_o` are all zero.
- R2: A 0-to-1 transition on `src_i[s]` sets `pend_o[s]` at the next clock edge. The bit stays set after the input falls. An input held high after its bit is cleared does not set it again.
- R3: `irq_o` is high in the cycle after a pending source has its `src_en_i` bit, its level's `lvl_mask_i` bit and `ie_o` all set. If any of the three is off, no request is raised for that source.
- R4: `lvl_rank_i` holds four 2-bit fields. Bits [1:0] name the highest-ranked level and bits [7:6] the lowest. The eligible source in the highest-ranked level wins.
- R5: If the four fields of `lvl_rank_i` are not a permutation of levels 0..3, the ranking falls back to ascending level number, with level 0 highest.
- R6: Among eligible sources in the same level, the lower source index wins.
- R7: `vec_o` equals `VEC_BASE + 4*winner`, with `VEC_BASE` = 0x40 by default.
- R8: An `ack_i` seen while `irq_o` is high does three things at that clock edge: it clears `ie_o`, it clears only the winner's pending bit, and it lowers `irq_o`.
- R9: A rising edge on the acknowledged source in the acknowledge cycle leaves its pending bit set.
- R10: `ret_i` or `ie_set_i` sets `ie_o` at the next edge. `ie_clr_i` clears `ie_o` and lowers `irq_o` at the next edge. An accepted acknowledge or `ie_clr_i` takes precedence over a set in the same cycle. When `ie_o` is re-enabled with an eligible source pending, `irq_o` rises at the same edge.
- R11: `ack_i` while `irq_o` is low changes neither `ie_o` nor `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 8 | Interrupt source lines, rising-edge sensitive |
| src_en_i | input | 8 | Per-source enables |
| lvl_mask_i | input | 4 | Per-level enables |
| lvl_rank_i | input | 8 | Level ranking, four 2-bit fields |
| ie_set_i | input | 1 | Strobe that sets the global enable |
| ie_clr_i | input | 1 | Strobe that clears the global enable |
| ret_i | input | 1 | Interrupt-return strobe, sets the global enable |
| ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 8 | Vector address of the current winner |
| ie_o | output | 1 | Global interrupt enable state |
| pend_o | output | 8 | Sticky pending bits |

## Verification
Two events can collide on one pending bit in the same cycle: the acknowledge that clears the winner's pending bit, and a fresh rising edge on that same source. The bench raises the source line in exactly the cycle that `ack_i` is driven. It then checks that the pending bit survives while the request and the global enable drop. After a return strobe, it checks that the request comes back with that source's vector. A second collision is also tested: `ie_clr_i` together with `ie_set_i`, where the clear must win.

// File: rtl/lpic_pkg.sv
package lpic_pkg;

    localparam int N_SRC    = 8;
    localparam int N_LVL    = 4;
    localparam int LVL_W    = $clog2(N_LVL);
    localparam int RANK_W   = N_LVL * LVL_W;
    localparam int SRC_W    = $clog2(N_SRC);
    localparam int PER_LVL  = N_SRC / N_LVL;
    localparam int VEC_W    = 8;
    localparam int VEC_STEP = 4;

    typedef logic [LVL_W-1:0]     lvl_t;
    typedef lvl_t [N_LVL-1:0]     order_t;
    typedef logic [SRC_W-1:0]     sidx_t;
    typedef logic [VEC_W-1:0]     vec_t;

    typedef struct packed {
        logic  vld;
        sidx_t idx;
    } win_t;

    // Decode the ranking register; entry 0 is the highest-ranked level.
    function automatic order_t decode_order(input logic [RANK_W-1:0] cfg);
        order_t            ord;
        logic [N_LVL-1:0]  seen;
        seen = '0;
        for (int i = 0; i < N_LVL; i++) begin
            ord[i] = cfg[i*LVL_W +: LVL_W];
            seen[ord[i]] = 1'b1;
        end
        if (seen != {N_LVL{1'b1}}) begin
            for (int i = 0; i < N_LVL; i++) ord[i] = lvl_t'(i);
        end
        return ord;
    endfunction

    function automatic lvl_t level_of(input int s);
        return lvl_t'(s / PER_LVL);
    endfunction

    function automatic vec_t vector_of(input vec_t base, input sidx_t idx);
        return base + vec_t'(idx) * vec_t'(VEC_STEP);
    endfunction

endpackage

// File: rtl/lpic_pend.sv
module lpic_pend
    import lpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] src_q;

    for (genvar s = 0; s < N_SRC; s++) begin : g_bit
        logic rise;
        assign rise = src_i[s] & ~src_q[s];

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[s]  <= 1'b0;
                pend_o[s] <= 1'b0;
            end else begin
                src_q[s]  <= src_i[s];
                // set beats clear so an edge in the acknowledge cycle survives
                pend_o[s] <= (pend_o[s] & ~clr_i[s]) | rise;
            end
        end
    end

endmodule

// File: rtl/lpic_arb.sv
module lpic_arb
    import lpic_pkg::*;
(
    input  logic [N_SRC-1:0]  req_i,
    input  logic [RANK_W-1:0] rank_i,
    output win_t              win_o
);

    order_t           order;
    logic [N_LVL-1:0] lvl_any;
    sidx_t            lvl_first [N_LVL];

    always_comb begin
        order = decode_order(rank_i);
        for (int l = 0; l < N_LVL; l++) begin
            lvl_any[l]   = 1'b0;
            lvl_first[l] = '0;
            for (int k = PER_LVL - 1; k >= 0; k--) begin
                if (req_i[l*PER_LVL + k]) begin
                    lvl_any[l]   = 1'b1;
                    lvl_first[l] = sidx_t'(l*PER_LVL + k);
                end
            end
        end
        win_o = '0;
        for (int r = N_LVL - 1; r >= 0; r--) begin
            if (lvl_any[order[r]]) begin
                win_o.vld = 1'b1;
                win_o.idx = lvl_first[order[r]];
            end
        end
    end

endmodule

// File: rtl/lpic_top.sv
module lpic_top
    import lpic_pkg::*;
#(
    parameter vec_t VEC_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [N_SRC-1:0]  src_en_i,
    input  logic [N_LVL-1:0]  lvl_mask_i,
    input  logic [RANK_W-1:0] lvl_rank_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              ret_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ie_o,
    output logic [N_SRC-1:0]  pend_o
);

    logic [N_SRC-1:0] lvl_ok;
    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] clr;
    win_t             win;
    sidx_t            win_q;
    logic             gie_q, gie_nxt, irq_q, take;
    vec_t             vec_q;

    for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
        assign lvl_ok[s] = lvl_mask_i[level_of(s)];
    end

    assign req  = pend_o & src_en_i & lvl_ok;
    assign take = ack_i & irq_q;
    assign clr  = take ? (N_SRC'(1) << win_q) : '0;

    lpic_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .clr_i  (clr),
        .pend_o (pend_o)
    );

    lpic_arb u_arb (
        .req_i  (req),
        .rank_i (lvl_rank_i),
        .win_o  (win)
    );

    always_comb begin
        if (take || ie_clr_i)          gie_nxt = 1'b0;
        else if (ret_i || ie_set_i)    gie_nxt = 1'b1;
        else                           gie_nxt = gie_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
            irq_q <= 1'b0;
            vec_q <= '0;
            win_q <= '0;
        end else begin
            gie_q <= gie_nxt;
            irq_q <= gie_nxt & win.vld;
            if (gie_nxt && win.vld) begin
                vec_q <= vector_of(VEC_BASE, win.idx);
                win_q <= win.idx;
            end
        end
    end

    assign irq_o = irq_q;
    assign vec_o = vec_q;
    assign ie_o  = gie_q;

endmodule

// File: rtl/lpic_chk.sv
module lpic_chk
    import lpic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ie_set_i,
    input logic             ie_clr_i,
    input logic             ret_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic             ie_o,
    input logic [N_SRC-1:0] pend_o
);

    a_r8_ack_enters: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> (!irq_o && !ie_o));

    a_r8_one_cleared: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> ($countones($past(pend_o) & ~pend_o) <= 1));

    a_r10_ret_sets: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !ie_clr_i && !(ack_i && irq_o)) |=> ie_o);

    a_r10_clr_drops: assert property (@(posedge clk) disable iff (rst)
        ie_clr_i |=> (!irq_o && !ie_o));

    a_r3_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ie_o && (pend_o != '0)));

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !(ack_i && irq_o) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    a_r11_stray_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !ie_clr_i && !ie_set_i && !ret_i) |=> (ie_o == $past(ie_o)));

endmodule

bind lpic_top lpic_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ie_set_i (ie_set_i),
    .ie_clr_i (ie_clr_i),
    .ret_i    (ret_i),
    .ack_i    (ack_i),
    .irq_o    (irq_o),
    .ie_o     (ie_o),
    .pend_o   (pend_o)
);

// File: tb/tb_lpic_top.sv
module tb_lpic_top;
    import lpic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 12;
    // [31:24] pulse, [23:16] src enable, [15:12] level mask, [11:4] ranking,
    // [3] request expected, [2:0] expected winner
    localparam logic [31:0] TBL [N_VEC] = '{
        32'h01FF_FE48,   // R3 single source
        32'h81FF_F1BF,   // R4 level 3 ranked first
        32'h0CFF_FE4A,   // R6 src2 beats src3
        32'h30FF_F1BC,   // R6 src4 beats src5
        32'h14FF_F4EC,   // R4 level 2 ranked first
        32'h14FF_F00A,   // R5 invalid ranking
        32'h81FF_F558,   // R5 invalid ranking
        32'h01FE_FE40,   // R3 source disabled
        32'h03FE_FE49,   // R3 disabled src0, src1 wins
        32'h05FF_EE4A,   // R3 level 0 masked
        32'h05FF_0E40,   // R3 all levels masked
        32'hC0FF_FE4E    // R6 src6 beats src7
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] src = '0, src_en = '0, rank = '0;
    logic [3:0] mask = '0;
    logic ie_set = 1'b0, ie_clr = 1'b0, ret = 1'b0, ack = 1'b0;
    logic irq, ie;
    logic [7:0] vec, pend;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpic_top dut (
        .clk(clk), .rst(rst), .src_i(src), .src_en_i(src_en),
        .lvl_mask_i(mask), .lvl_rank_i(rank), .ie_set_i(ie_set),
        .ie_clr_i(ie_clr), .ret_i(ret), .ack_i(ack),
        .irq_o(irq), .vec_o(vec), .ie_o(ie), .pend_o(pend)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; src = '0; src_en = '0; mask = '0; rank = '0;
        ie_set = 0; ie_clr = 0; ret = 0; ack = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic arm(input logic [7:0] p, input logic [7:0] en,
                       input logic [3:0] m, input logic [7:0] r);
        src_en = en; mask = m; rank = r;
        ie_set = 1'b1; src = p;
        tick();
        ie_set = 1'b0; src = '0;
        tick();
    endtask

    initial begin
        tick();
        do_reset();
        chk("R1 irq", irq, 0);
        chk("R1 ie", ie, 0);
        chk("R1 pend", pend, 0);
        chk("R1 vec", vec, 0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [31:0] e;
            e = TBL[i];
            do_reset();
            arm(e[31:24], e[23:16], e[15:12], e[11:4]);
            chk($sformatf("R3/R4/R5/R6 row %0d irq", i), irq, e[3]);
            if (e[3]) chk($sformatf("R7 row %0d vec", i), vec, 8'h40 + 4*e[2:0]);
            chk($sformatf("R10 row %0d ie", i), ie, 1);
        end

        // R8: acknowledge clears only the winner, then R10 return re-arms
        do_reset();
        arm(8'h05, 8'hFF, 4'hF, 8'hE4);
        chk("R7 vec src0", vec, 8'h40);
        ack = 1'b1; tick(); ack = 1'b0;
        chk("R8 irq after ack", irq, 0);
        chk("R8 ie after ack", ie, 0);
        chk("R8 pend after ack", pend, 8'h04);
        tick();
        chk("R8 stays idle", irq, 0);
        ret = 1'b1; tick(); ret = 1'b0;
        chk("R10 ie after ret", ie, 1);
        chk("R10 irq after ret", irq, 1);
        chk("R10 vec after ret", vec, 8'h48);

        // R9: new edge on acknowledged source during ack cycle
        do_reset();
        arm(8'h01, 8'hFF, 4'hF, 8'hE4);
        ack = 1'b1; src = 8'h01; tick(); ack = 1'b0; src = '0;
        chk("R9 pend kept", pend, 8'h01);
        chk("R9 irq low", irq, 0);
        chk("R9 ie low", ie, 0);
        ret = 1'b1; tick(); ret = 1'b0;
        chk("R9 irq again", irq, 1);
        chk("R9 vec again", vec, 8'h40);

        // R2: sticky bit, and a held line does not re-set it
        do_reset();
        src_en = 8'hFF; mask = 4'hF; rank = 8'hE4;
        src = 8'h01; tick(); tick(); src = '0; tick();
        chk("R2 pend sticky", pend, 8'h01);
        chk("R3 no irq with ie off", irq, 0);
        ie_set = 1'b1; tick(); ie_set = 1'b0;
        chk("R10 irq with ie_set", irq, 1);
        src = 8'h01; tick();
        ack = 1'b1; tick(); ack = 1'b0;
        tick();
        chk("R2 held line no reset", pend, 8'h00);
        chk("R2 held line irq", irq, 0);
        src = '0;

        // R10: clear strobe drops request; clear beats set
        do_reset();
        arm(8'h01, 8'hFF, 4'hF, 8'hE4);
        ie_clr = 1'b1; tick(); ie_clr = 1'b0;
        chk("R10 clr irq", irq, 0);
        chk("R10 clr ie", ie, 0);
        chk("R10 clr keeps pend", pend, 8'h01);
        ie_clr = 1'b1; ie_set = 1'b1; tick(); ie_clr = 1'b0; ie_set = 1'b0;
        chk("R10 clr beats set", ie, 0);

        // R11: stray acknowledge with no request
        do_reset();
        arm(8'h02, 8'hFD, 4'hF, 8'hE4);
        chk("R3 src1 disabled", irq, 0);
        ack = 1'b1; tick(); ack = 1'b0;
        chk("R11 pend kept", pend, 8'h02);
        chk("R11 ie kept", ie, 1);
        chk("R11 irq low", irq, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule